// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter

This block sends bytes on a single serial line, one bit per baud tick. A one-word holding register sits in front of the shift register. A byte written by the CPU waits in the holding register until the shift register can accept it. The byte then moves into the shift register, and the holding register reports itself empty at once. Software can therefore queue the next byte while the current one is still going out. The empty flag, ANDed with an interrupt enable, forms a level-sensitive interrupt request.

Three framing modes are supported. In plain asynchronous mode a frame is a low start bit, eight data bits least significant first, and a high stop bit. In marker mode a frame has the same layout, plus one address/data bit between the last data bit and the stop bit. In synchronous mode only the data bits go out, with no framing bits. In this mode a shift clock output pulses low for each bit. The mode and the marker value are captured when a byte enters the shift register. Baud generation is not part of this block: the caller supplies a one-cycle `tick` strobe per bit period.

Top module: `sertx_dbuf`

## Requirements
- R1: After reset `hold_empty` is 1. It returns to 1 on the tick that moves the held byte into the shift register, which is the same tick that puts the frame's first bit on `txd`.
- R2: A write (`wr_en` high) clears `hold_empty` in the next cycle. A write made while the holding register is already full replaces the held byte, and only the later byte is sent.
- R3: `irq` equals `hold_empty` AND `irq_en` as a level. While `irq_en` stays high, `irq` falls only after a write.
- R4: With `mode` = 2'b00 a frame is: 0, D0 to D7 least significant first, then 1. Each bit holds `txd` for exactly one tick period, and `txd` changes only on a cycle that follows a tick.
- R5: With `mode` = 2'b01 the frame carries one extra bit after D7 and before the stop bit. Its value is `adr_bit`.
- R6: With `mode[1]` = 1 only D0 to D7 are sent, with no start or stop bit. `sclk` is 0 for the one clock cycle after each tick that launches a data bit, and 1 at all other times, including idle and asynchronous modes.
- R7: If a byte is held when the last bit of a frame ends, the next tick launches that byte's first bit with no idle bit in between. If no byte is held, that tick returns `txd` to 1.
- R8: A byte written while the shifter is idle goes out starting on the first tick after the write cycle. A tick in the same cycle as the write does not load it.
- R9: After reset `txd` and `sclk` are 1.
- R10: `mode` and `adr_bit` are sampled only when a byte enters the shift register. Changing them mid-frame does not affect the frame in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the holding register |
| wr_data | input | DW | Byte to transmit |
| mode | input | 2 | 00 plain async, 01 async with marker bit, 1x synchronous |
| adr_bit | input | 1 | Marker bit value for mode 01 |
| tick | input | 1 | One-cycle bit-period strobe |
| irq_en | input | 1 | Interrupt enable |
| txd | output | 1 | Serial data line, idle high |
| sclk | output | 1 | Shift clock for synchronous mode, idle high |
| hold_empty | output | 1 | Holding register empty flag |
| irq | output | 1 | Transmit interrupt request |

## Verification
The bench uses the default width DW = 8. It draws the mode from all four codes, so both synchronous codes are exercised. It picks the preload moment at any bit index of the current frame, or skips the preload. This covers back-to-back frames with a mode change at every boundary position, as well as idle gaps. Directed cases cover overwriting the held byte, a write that coincides with a tick, and a disabled interrupt.

// File: rtl/sertx_dbuf.sv
module sertx_dbuf #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic [1:0]    mode,
  input  logic          adr_bit,
  input  logic          tick,
  input  logic          irq_en,
  output logic          txd,
  output logic          sclk,
  output logic          hold_empty,
  output logic          irq
);
  localparam int FW = DW + 3;
  localparam int CW = $clog2(FW + 1);
  localparam logic [CW-1:0] LEN_SYNC = CW'(DW);
  localparam logic [CW-1:0] LEN_PLAIN = CW'(DW + 2);
  localparam logic [CW-1:0] LEN_MARK = CW'(DW + 3);

  logic [DW-1:0] hold_q;
  logic          empty_q;
  logic [FW-1:0] sh_q;
  logic [CW-1:0] left_q;
  logic          txd_q, sclk_q, sync_q;
  logic [FW-1:0] frm;
  logic [CW-1:0] len;

  wire load  = tick && (left_q <= 1) && !empty_q;
  wire shift = tick && (left_q > 1);

  always_comb begin
    if (mode[1]) begin
      frm = {3'b111, hold_q};
      len = LEN_SYNC;
    end else if (mode[0]) begin
      frm = {1'b1, adr_bit, hold_q, 1'b0};
      len = LEN_MARK;
    end else begin
      frm = {2'b11, hold_q, 1'b0};
      len = LEN_PLAIN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      empty_q <= 1'b1;
      sh_q    <= '1;
      left_q  <= '0;
      txd_q   <= 1'b1;
      sclk_q  <= 1'b1;
      sync_q  <= 1'b0;
    end else begin
      if (wr_en) begin
        hold_q  <= wr_data;
        empty_q <= 1'b0;
      end else if (load) begin
        empty_q <= 1'b1;
      end
      sclk_q <= 1'b1;
      if (load) begin
        sh_q   <= frm;
        left_q <= len;
        txd_q  <= frm[0];
        sync_q <= mode[1];
        if (mode[1]) sclk_q <= 1'b0;
      end else if (shift) begin
        sh_q   <= {1'b1, sh_q[FW-1:1]};
        left_q <= left_q - 1'b1;
        txd_q  <= sh_q[1];
        if (sync_q) sclk_q <= 1'b0;
      end else if (tick) begin
        left_q <= '0;
        txd_q  <= 1'b1;
      end
    end
  end

  assign txd        = txd_q;
  assign sclk       = sclk_q;
  assign hold_empty = empty_q;
  assign irq        = empty_q & irq_en;
endmodule

// File: rtl/sertx_dbuf_chk.sv
module sertx_dbuf_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic tick,
  input logic irq_en,
  input logic txd,
  input logic sclk,
  input logic hold_empty,
  input logic irq
);
  // R2
  wr_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !hold_empty);
  // R1
  empty_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold_empty) |-> $past(tick));
  // R4
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(txd));
  // R3
  irq_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> ($past(wr_en) || !irq_en));
  // R6
  sclk_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sclk |-> $past(tick));
endmodule

bind sertx_dbuf sertx_dbuf_chk i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .tick(tick), .irq_en(irq_en),
  .txd(txd), .sclk(sclk), .hold_empty(hold_empty), .irq(irq)
);

// File: tb/test_sertx_dbuf.sv
`timescale 1ns/1ps
module test_sertx_dbuf;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, adr_bit = 1'b0, tick = 1'b0, irq_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [1:0] mode = 2'b00;
  logic txd, sclk, hold_empty, irq;
  int checks = 0, errors = 0;
  logic o_txd, o_sclk, m_txd, m_sclk;

  sertx_dbuf #(.DW(8)) i_sertx_dbuf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .mode(mode),
    .adr_bit(adr_bit), .tick(tick), .irq_en(irq_en), .txd(txd), .sclk(sclk),
    .hold_empty(hold_empty), .irq(irq)
  );

  always #2.5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int flen(input logic [1:0] m);
    return m[1] ? 8 : (m[0] ? 11 : 10);
  endfunction

  function automatic logic fbit(input logic [1:0] m, input logic [7:0] d, input logic a, input int i);
    if (m[1]) return d[i];
    if (i == 0) return 1'b0;
    if (i <= 8) return d[i-1];
    if (m[0] && i == 9) return a;
    return 1'b1;
  endfunction

  function automatic string mtag(input logic [1:0] m);
    return m[1] ? "R6" : (m[0] ? "R5" : "R4");
  endfunction

  task automatic write(input logic [7:0] d);
    @(negedge clk) wr_en = 1'b1; wr_data = d;
    @(negedge clk) wr_en = 1'b0;
  endtask

  task automatic step_tick();
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    o_txd = txd; o_sclk = sclk;
    @(negedge clk);
    m_txd = txd; m_sclk = sclk;
  endtask

  // Runs one frame; optionally preloads the next byte after bit pre_at.
  task automatic run_frame(input logic [1:0] m, input logic [7:0] d, input logic a,
                           input int pre_at, input logic [1:0] nm,
                           input logic [7:0] nd, input logic na);
    for (int i = 0; i < flen(m); i++) begin
      step_tick();
      check(o_txd === fbit(m, d, a, i), mtag(m), o_txd, fbit(m, d, a, i));
      check(o_sclk === (m[1] ? 1'b0 : 1'b1), "R6", o_sclk, m[1] ? 0 : 1);
      check(m_sclk === 1'b1, "R6", m_sclk, 1);
      check(m_txd === o_txd, "R4", m_txd, o_txd);
      if (i == 0) begin
        check(hold_empty === 1'b1, "R1", hold_empty, 1);
        check(irq === irq_en, "R3", irq, irq_en);
      end
      if (i == pre_at) begin
        mode = nm; adr_bit = na; // R10: new values must not touch this frame
        write(nd);
        check(hold_empty === 1'b0, "R2", hold_empty, 0);
        check(irq === 1'b0, "R3", irq, 0);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [1:0] cm, nm;
    logic [7:0] cd, nd;
    logic ca, na;
    int pre;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R9 R1 reset state
    check(txd === 1'b1, "R9", txd, 1);
    check(sclk === 1'b1, "R9", sclk, 1);
    check(hold_empty === 1'b1, "R1", hold_empty, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(irq === 1'b0, "R3", irq, 0);
    irq_en = 1'b1;
    #1 check(irq === 1'b1, "R3", irq, 1);

    // R8: write coinciding with a tick is not loaded by that tick
    @(negedge clk) wr_en = 1'b1; wr_data = 8'hA5; tick = 1'b1; mode = 2'b00;
    @(negedge clk) wr_en = 1'b0; tick = 1'b0;
    check(hold_empty === 1'b0, "R8", hold_empty, 0);
    check(txd === 1'b1, "R8", txd, 1);
    run_frame(2'b00, 8'hA5, 1'b0, -1, 2'b00, 8'h00, 1'b0);
    step_tick();
    check(o_txd === 1'b1, "R7", o_txd, 1);

    // R2: overwrite held byte before any tick
    write(8'h3C); write(8'hC3);
    run_frame(2'b00, 8'hC3, 1'b0, -1, 2'b00, 8'h00, 1'b0);
    step_tick();

    // R3: irq masked when enable low
    irq_en = 1'b0;
    @(negedge clk);
    check(irq === 1'b0 && hold_empty === 1'b1, "R3", irq, 0);

    // R6 R7: synchronous back-to-back bytes
    mode = 2'b10; write(8'h96);
    run_frame(2'b10, 8'h96, 1'b0, 3, 2'b10, 8'h5A, 1'b0);
    run_frame(2'b10, 8'h5A, 1'b0, -1, 2'b00, 8'h00, 1'b0);
    step_tick();
    check(o_txd === 1'b1 && o_sclk === 1'b1, "R7", o_sclk, 1);

    // constrained random: all modes, preload at any bit or none
    cm = 2'($urandom_range(3)); cd = 8'($urandom); ca = 1'($urandom);
    mode = cm; adr_bit = ca; write(cd);
    for (int k = 0; k < 80; k++) begin
      nm = 2'($urandom_range(3)); nd = 8'($urandom); na = 1'($urandom);
      irq_en = 1'($urandom);
      pre = ($urandom_range(3) == 0) ? -1 : int'($urandom_range(flen(cm) - 1));
      run_frame(cm, cd, ca, pre, nm, nd, na);
      if (pre < 0) begin
        step_tick();
        check(o_txd === 1'b1, "R7", o_txd, 1);
        check(hold_empty === 1'b1, "R1", hold_empty, 1);
        mode = nm; adr_bit = na; write(nd);
      end
      cm = nm; cd = nd; ca = na;
    end
    run_frame(cm, cd, ca, -1, 2'b00, 8'h00, 1'b0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule